// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Generator

This block produces the bit timing for one channel of a serial controller. The operating clock passes first through a prescaler whose ratio is a power of four (1, 4, 16 or 64). It then passes through an 8-bit reload divider that counts N+1 prescaler enables. The result is a base unit of U = 4^n × (N+1) clock cycles. Every second unit, the block emits an oversampling tick. The bit tick fires after a mode-dependent number of oversampling ticks: 16 in asynchronous mode, 2 in clocked synchronous mode, and the element-time factor S (32, 64, 372 or 256) in smart-card mode. In clocked synchronous mode a serial clock toggles on every oversampling tick.

Each channel holds its own divisor, so channels can run at different rates. The divisor and the mode word can be written and read back at any time. Any write restarts all internal counters so that the new rate begins from a clean phase. A low generator enable freezes the block in that same clean state. The block moves no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `serial_rate_gen`

## Requirements
- R1: After reset, the divisor readback is 0xFF and the mode word readback is 0. Written values read back on the next cycle. Mode word fields: bits [1:0] are the mode (00 asynchronous, 01 clocked synchronous, 10 smart-card, 11 treated as asynchronous), bits [3:2] are the prescaler select n, and bits [5:4] are the element-time select.
- R2: Counting cycles from c = 0 as the first cycle with a clean phase and the enable high, os_tick is high exactly in the cycles where (c+1) is a multiple of 2 × 4^n × (N+1).
- R3: In asynchronous mode, bit_tick is high exactly in the cycles where (c+1) is a multiple of 32 × 4^n × (N+1), which is every 16th oversampling tick.
- R4: In clocked synchronous mode, sclk starts low and toggles after every oversampling tick. bit_tick is high exactly in the cycles where (c+1) is a multiple of 4 × 4^n × (N+1), which are the cycles that end with sclk falling.
- R5: In smart-card mode, bit_tick is high exactly in the cycles where (c+1) is a multiple of 2 × S × 4^n × (N+1). The element-time select picks S: 00 gives 32, 01 gives 64, 10 gives 372 and 11 gives 256.
- R6: Mode value 11 produces the same os_tick and bit_tick timing as asynchronous mode.
- R7: While gen_en is low, os_tick and bit_tick stay low, sclk stays low, and all counters hold their clean phase. Timing after gen_en rises again follows R2 to R5 from c = 0.
- R8: A write to the divisor or to the mode word suppresses ticks in the write cycle. Timing then restarts from c = 0 in the following cycle.
- R9: sclk stays low in every mode other than clocked synchronous.
- R10: os_tick never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable; low holds a clean phase |
| cfg_we_div | input | 1 | Write strobe for the divisor |
| cfg_div_wdata | input | 8 | Divisor value N |
| cfg_we_mode | input | 1 | Write strobe for the mode word |
| cfg_mode_wdata | input | 6 | Mode word: [1:0] mode, [3:2] prescaler select, [5:4] element-time select |
| rd_div | output | 8 | Divisor readback |
| rd_mode | output | 6 | Mode word readback |
| os_tick | output | 1 | Single-cycle oversampling enable |
| bit_tick | output | 1 | Single-cycle bit-period enable |
| sclk | output | 1 | Serial clock for clocked synchronous mode |

## Verification
The tick outputs are decoded combinationally from counter state. This means each pulse is visible in the same cycle that the counters reach it: cycle c = 2U−1 for the first oversampling tick, and cycle c = 2UK−1 for the first bit tick, where K is the mode's tick count. sclk is a register, so it changes one cycle after the oversampling tick that toggles it. A register write takes effect at the write edge, which makes the very next cycle c = 0. The bench drives inputs on the falling edge and samples one nanosecond later. From the first enabled cycle it compares every cycle against the arithmetic predictions for at least two full bit periods. The sweep covers each mode, prescaler select and element-time select over several divisors.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_CARD  = 2'b10,
    MODE_ALT   = 2'b11
  } srg_mode_e;

  localparam int unsigned ASYNC_OS_PER_BIT = 16;
  localparam int unsigned SYNC_OS_PER_BIT  = 2;
  localparam int unsigned MAX_OS_PER_BIT   = 372;
  localparam int unsigned OSCNT_W          = $clog2(MAX_OS_PER_BIT + 1);

  // Element-time factor for smart-card mode.
  function automatic int unsigned card_factor(input logic [1:0] sel);
    case (sel)
      2'b00:   return 32;
      2'b01:   return 64;
      2'b10:   return 372;
      default: return 256;
    endcase
  endfunction

  // Oversampling ticks per bit for each mode.
  function automatic int unsigned os_per_bit(input srg_mode_e mode,
                                             input logic [1:0] etf);
    case (mode)
      MODE_SYNC: return SYNC_OS_PER_BIT;
      MODE_CARD: return card_factor(etf);
      default:   return ASYNC_OS_PER_BIT;
    endcase
  endfunction

endpackage

// File: rtl/srg_cfg_regs.sv
module srg_cfg_regs #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned PSEL_W = 2,
  localparam int unsigned MODE_W = 4 + PSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_div,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              we_mode,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_load,
  output logic [MODE_W-1:0] mode_word,
  output logic              clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '1;
      mode_word <= '0;
    end else begin
      if (we_div)  div_q     <= div_wdata;
      if (we_mode) mode_word <= mode_wdata;
    end
  end

  assign div_load = we_div ? div_wdata : div_q;
  assign clr      = we_div | we_mode;

endmodule

// File: rtl/srg_prescaler.sv
module srg_prescaler #(
  parameter int unsigned PSEL_W = 2,
  localparam int unsigned PRE_W = 2 * ((1 << PSEL_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [PSEL_W-1:0] psel,
  output logic              pre_en
);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W:0]   span;
  logic [PRE_W:0]   lim;

  assign span   = (PRE_W+1)'(1) << (2 * psel);
  assign lim    = span - (PRE_W+1)'(1);
  assign pre_en = run && !clr && (pcnt == lim[PRE_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (clr || !run)    pcnt <= '0;
    else if (pre_en)         pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

  // R2: prescaler count never passes the selected limit
  assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pcnt} <= lim));

endmodule

// File: rtl/srg_reload_div.sv
module srg_reload_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             pre_en,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_load,
  output logic             unit
);

  logic [DIV_W-1:0] dcnt;

  assign unit = pre_en && (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt <= '1;
    else if (clr)     dcnt <= div_load;
    else if (!run)    dcnt <= div_q;
    else if (pre_en)  dcnt <= (dcnt == '0) ? div_q : dcnt - 1'b1;
  end

  // R2: terminal count reloads the stored divisor
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unit |=> (dcnt == $past(div_q)));

endmodule

// File: rtl/srg_tick_shaper.sv
module srg_tick_shaper
  import srg_pkg::*;
#(
  parameter int unsigned CNT_W = OSCNT_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      clr,
  input  logic      unit,
  input  srg_mode_e mode,
  input  logic [1:0] etf,
  output logic      os_tick,
  output logic      bit_tick,
  output logic      sclk
);

  logic             half;
  logic [CNT_W-1:0] bcnt;
  logic [CNT_W-1:0] k_last;

  assign k_last   = CNT_W'(os_per_bit(mode, etf) - 1);
  assign os_tick  = unit && half;
  assign bit_tick = os_tick && (bcnt == k_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half <= 1'b0;
      bcnt <= '0;
      sclk <= 1'b0;
    end else if (clr || !run) begin
      half <= 1'b0;
      bcnt <= '0;
      sclk <= 1'b0;
    end else begin
      if (unit) half <= ~half;
      if (os_tick) begin
        bcnt <= (bcnt == k_last) ? '0 : bcnt + 1'b1;
        if (mode == MODE_SYNC) sclk <= ~sclk;
      end
      if (mode != MODE_SYNC) sclk <= 1'b0;
    end
  end

  // R10: oversampling tick lasts one cycle
  assert_os_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);

  // R9: serial clock idle outside synchronous mode
  assert_sclk_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_SYNC) |-> !sclk);

  // R5: tick counter stays inside the selected element length
  assert_bcnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt <= k_last));

  // R4: a synchronous bit tick ends with sclk falling
  assert_sync_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && mode == MODE_SYNC) |=> !sclk);

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import srg_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned PSEL_W = 2,
  localparam int unsigned MODE_W = 4 + PSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              cfg_we_div,
  input  logic [DIV_W-1:0]  cfg_div_wdata,
  input  logic              cfg_we_mode,
  input  logic [MODE_W-1:0] cfg_mode_wdata,
  output logic [DIV_W-1:0]  rd_div,
  output logic [MODE_W-1:0] rd_mode,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              sclk
);

  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_load;
  logic [MODE_W-1:0] mode_word;
  logic              clr;
  logic              pre_en;
  logic              unit;
  srg_mode_e         mode;

  srg_cfg_regs #(.DIV_W(DIV_W), .PSEL_W(PSEL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_div     (cfg_we_div),
    .div_wdata  (cfg_div_wdata),
    .we_mode    (cfg_we_mode),
    .mode_wdata (cfg_mode_wdata),
    .div_q      (div_q),
    .div_load   (div_load),
    .mode_word  (mode_word),
    .clr        (clr)
  );

  assign mode = srg_mode_e'(mode_word[1:0]);

  srg_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (gen_en),
    .clr    (clr),
    .psel   (mode_word[2 +: PSEL_W]),
    .pre_en (pre_en)
  );

  srg_reload_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (gen_en),
    .clr      (clr),
    .pre_en   (pre_en),
    .div_q    (div_q),
    .div_load (div_load),
    .unit     (unit)
  );

  srg_tick_shaper u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (gen_en),
    .clr      (clr),
    .unit     (unit),
    .mode     (mode),
    .etf      (mode_word[2+PSEL_W +: 2]),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .sclk     (sclk)
  );

  assign rd_div  = div_q;
  assign rd_mode = mode_word;

  // R8: the cycle after any write is too early for an oversampling tick
  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_div || cfg_we_mode) |=> !os_tick);

  // R7: disabled generator leaves sclk low and no tick
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!sclk && !os_tick));

  // R1: written divisor is visible on the next cycle
  assert_div_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_div |=> (rd_div == $past(cfg_div_wdata)));

endmodule

// File: tb/serial_rate_gen_bench.sv
module serial_rate_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_en = 1'b0;
  logic       cfg_we_div = 1'b0;
  logic [7:0] cfg_div_wdata = 8'h00;
  logic       cfg_we_mode = 1'b0;
  logic [5:0] cfg_mode_wdata = 6'h00;
  logic [7:0] rd_div;
  logic [5:0] rd_mode;
  logic       os_tick, bit_tick, sclk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_rate_gen u_serial_rate_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
    .cfg_we_div(cfg_we_div), .cfg_div_wdata(cfg_div_wdata),
    .cfg_we_mode(cfg_we_mode), .cfg_mode_wdata(cfg_mode_wdata),
    .rd_div(rd_div), .rd_mode(rd_mode),
    .os_tick(os_tick), .bit_tick(bit_tick), .sclk(sclk)
  );

  function automatic int s_of(input int etf);
    case (etf)
      0: return 32;
      1: return 64;
      2: return 372;
      default: return 256;
    endcase
  endfunction

  function automatic int k_of(input int mode, input int etf);
    if (mode == 1) return 2;
    if (mode == 2) return s_of(etf);
    return 16;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Write both registers with the generator stopped; leaves the bench at a falling edge.
  task automatic configure(input int mode, input int psel, input int etf, input int n);
    @(negedge clk);
    gen_en = 1'b0;
    cfg_we_div = 1'b1;  cfg_div_wdata = 8'(n);
    cfg_we_mode = 1'b1; cfg_mode_wdata = {2'(etf), 2'(psel), 2'(mode)};
    @(negedge clk);
    cfg_we_div = 1'b0; cfg_we_mode = 1'b0;
    #1;
    check(rd_div == 8'(n), "R1", "divisor readback", rd_div, n);
    check(rd_mode == {2'(etf), 2'(psel), 2'(mode)}, "R1", "mode readback",
          rd_mode, {2'(etf), 2'(psel), 2'(mode)});
    @(negedge clk);
  endtask

  // Compare every cycle from c=0 (current sample point) for len cycles.
  task automatic run_compare(input int mode, input int psel, input int etf, input int n,
                             input int len, input string req);
    int u = (1 << (2 * psel)) * (n + 1);
    int k = k_of(mode, etf);
    int bad_os = 0, bad_bit = 0, bad_sclk = 0;
    int a_os = 0, e_os = 0, a_bit = 0, e_bit = 0, a_sc = 0, e_sc = 0;
    for (int c = 0; c < len; c++) begin
      int eo, eb, es;
      #1;
      eo = ((c + 1) % (2 * u) == 0) ? 1 : 0;
      eb = ((c + 1) % (2 * u * k) == 0) ? 1 : 0;
      es = (mode == 1) ? ((c / (2 * u)) % 2) : 0;
      if (int'(os_tick) != eo && bad_os == 0) begin a_os = os_tick; e_os = eo; end
      if (int'(os_tick) != eo) bad_os++;
      if (int'(bit_tick) != eb && bad_bit == 0) begin a_bit = bit_tick; e_bit = eb; end
      if (int'(bit_tick) != eb) bad_bit++;
      if (int'(sclk) != es && bad_sclk == 0) begin a_sc = sclk; e_sc = es; end
      if (int'(sclk) != es) bad_sclk++;
      @(negedge clk);
    end
    check(bad_os == 0, "R2", $sformatf("os_tick mode=%0d n=%0d N=%0d", mode, psel, n), a_os, e_os);
    check(bad_bit == 0, req, $sformatf("bit_tick mode=%0d n=%0d N=%0d S=%0d", mode, psel, n, etf),
          a_bit, e_bit);
    check(bad_sclk == 0, (mode == 1) ? "R4" : "R9",
          $sformatf("sclk mode=%0d n=%0d N=%0d", mode, psel, n), a_sc, e_sc);
  endtask

  task automatic sweep(input int mode, input int psel, input int etf, input int n,
                       input string req);
    int len = 4 * (1 << (2 * psel)) * (n + 1) * k_of(mode, etf) + 3;
    configure(mode, psel, etf, n);
    gen_en = 1'b1;
    run_compare(mode, psel, etf, n, len, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(rd_div == 8'hFF, "R1", "reset divisor", rd_div, 255);
    check(rd_mode == 6'h00, "R1", "reset mode word", rd_mode, 0);
    check(!os_tick && !bit_tick && !sclk, "R1", "reset outputs",
          {os_tick, bit_tick, sclk}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset divisor 0xFF, prescaler 0: asynchronous timing from default state
    @(negedge clk);
    gen_en = 1'b1;
    run_compare(0, 0, 0, 255, 2 * 32 * 256 + 3, "R3");

    // R3 asynchronous sweep over prescaler and divisor
    for (int p = 0; p < 4; p++) begin
      sweep(0, p, 0, 0, "R3");
      sweep(0, p, 0, 2, "R3");
    end

    // R4 synchronous sweep
    for (int p = 0; p < 4; p++) begin
      sweep(1, p, 0, 0, "R4");
      sweep(1, p, 0, 2, "R4");
    end

    // R5 smart-card: all element-time selects
    for (int e = 0; e < 4; e++) begin
      for (int p = 0; p < 2; p++) begin
        sweep(2, p, e, 0, "R5");
        sweep(2, p, e, 2, "R5");
      end
    end

    // R6 mode 11 behaves as asynchronous
    sweep(3, 0, 2, 1, "R6");
    sweep(3, 1, 0, 0, "R6");

    // R7 enable low mid-run: quiet, then clean restart
    configure(1, 0, 0, 1);
    gen_en = 1'b1;
    repeat (11) @(negedge clk);
    gen_en = 1'b0;
    begin
      int noisy = 0;
      for (int c = 0; c < 300; c++) begin
        #1;
        if (os_tick || bit_tick || sclk) noisy++;
        @(negedge clk);
      end
      check(noisy == 0, "R7", "activity while disabled", noisy, 0);
    end
    gen_en = 1'b1;
    run_compare(1, 0, 0, 1, 40, "R7");

    // R8 divisor write mid-run restarts phase, no tick in write cycle
    configure(0, 0, 0, 3);
    gen_en = 1'b1;
    repeat (37) @(negedge clk);
    cfg_we_div = 1'b1; cfg_div_wdata = 8'd3;
    for (int c = 0; c < 7; c++) begin
      #1;
      if (os_tick) break;
      @(posedge clk);
      if (c == 0) break;
    end
    @(negedge clk);
    cfg_we_div = 1'b0;
    run_compare(0, 0, 0, 3, 4 * 16 * 4 + 3, "R8");

    // R8 write cycle itself is quiet: pick a write landing on a due tick (U=1, os at odd c)
    configure(0, 0, 0, 0);
    gen_en = 1'b1;
    @(negedge clk);           // c=1 now: os due
    #1;
    check(os_tick == 1'b1, "R2", "os due at c=1", os_tick, 1);
    @(negedge clk);           // c=2
    @(negedge clk);           // c=3: os due, but write this cycle
    cfg_we_mode = 1'b1; cfg_mode_wdata = 6'h00;
    #1;
    check(os_tick == 1'b0, "R8", "tick in write cycle", os_tick, 0);
    @(negedge clk);
    cfg_we_mode = 1'b0;
    run_compare(0, 0, 0, 0, 70, "R8");

    // R10 single-cycle os tick at fastest rate, sampled every cycle
    begin
      int doubles = 0;
      int prev = 0;
      configure(2, 0, 0, 0);
      gen_en = 1'b1;
      for (int c = 0; c < 200; c++) begin
        #1;
        if (prev == 1 && os_tick) doubles++;
        prev = os_tick;
        @(negedge clk);
      end
      check(doubles == 0, "R10", "consecutive os ticks", doubles, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule